// File: doc/BRIEF.md
# Cache Set Index Generator

This block turns a full byte address into the set number of a set-associative cache. The indexing policy is chosen per request. A linear policy takes the address bits just above the line offset. A pseudo-random polynomial policy folds address bits 7 through 26 through fixed XOR trees, which spreads strided access streams across the sets. The polynomial trees are defined only for caches of 32 or 64 sets.

A request carries the address, a policy code, the set count as a log2 and the line size as a log2. One clock later the block returns the set index with a valid strobe and an error flag. The error flag marks a policy code or set count that the block does not support. Three policy codes (bitwise-XOR, legacy hash and custom) are accepted but give the linear result. The lookup pipeline places the block in front of its tag array.

Top module: `set_index_gen`

## Requirements
- R1: While reset is active, and on the first clock after reset, `idx_valid_o`, `idx_err_o` and `idx_o` are all 0.
- R2: Policy code 0 (linear) with set log2 S in 0..6 gives `idx_o = (addr >> line_log2) & (2^S - 1)`. Bits at or above S are zero.
- R3: Policy code 2 (polynomial hash) with S = 5 gives index bits 0..4, each the XOR of a set of address bits. Bit 0 uses {7,12,15,17,18,21,22,23,24,25}. Bit 1 uses {8,13,16,18,19,22,23,24,25,26}. Bit 2 uses {9,12,14,15,18,19,20,21,22,26}. Bit 3 uses {10,13,15,16,19,20,21,22,23}. Bit 4 uses {11,14,16,17,20,21,22,23,24}. Index bit 5 is 0.
- R4: Policy code 2 with S = 6 gives the same bits 0..4 as R3. Index bit 5 equals address bit 12.
- R5: Policy code 2 with S other than 5 or 6 raises `idx_err_o`.
- R6: Policy codes 1 (bitwise-XOR), 3 (legacy hash) and 4 (custom) give exactly the linear result of R2 without error.
- R7: Policy codes 5, 6 and 7 raise `idx_err_o` for any set count.
- R8: A set log2 of 7 raises `idx_err_o` under every policy.
- R9: `idx_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high. Without a request, `idx_o` keeps its last value and `idx_err_o` is low.
- R10: A request that raises `idx_err_o` also raises `idx_valid_o` and gives `idx_o = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_addr_i | input | ADDR_W | Full byte address |
| req_policy_i | input | 3 | Policy code (0 linear, 1 bitwise-XOR, 2 polynomial hash, 3 legacy hash, 4 custom) |
| req_sets_log2_i | input | 3 | log2 of the set count (0..6 supported) |
| req_line_log2_i | input | LINE_W | log2 of the line size in bytes |
| idx_o | output | 6 | Registered set index, zero-extended |
| idx_valid_o | output | 1 | Result strobe, one cycle after the request |
| idx_err_o | output | 1 | The request had an unsupported combination |

## Verification
The bench builds the block with its default 64-bit address and 6-bit line-log2 width. This makes every line shift from 0 to 63 reachable, and it lets random addresses set the bits above bit 26 that the hash must ignore. Random requests cover all eight policy codes and all eight set counts, so the error paths for codes 5..7, set log2 7 and the hash at unsupported sizes are all hit. Directed requests put one-hot addresses on each hashed bit and check the bit-12 path for 64 sets.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int IDX_W       = 6;
  localparam int SETS_W      = 3;
  localparam int POL_W       = 3;
  localparam int SETS_LOG2_MAX = 6;
  localparam int HASH_MSB    = 26;

  typedef enum logic [POL_W-1:0] {
    POL_LINEAR   = 3'd0,
    POL_XORPERM  = 3'd1,
    POL_POLYHASH = 3'd2,
    POL_LEGACY   = 3'd3,
    POL_CUSTOM   = 3'd4
  } policy_e;
endpackage

// File: rtl/sidx_linear.sv
module sidx_linear
  import sidx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LINE_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINE_W-1:0] line_log2,
  input  logic [SETS_W-1:0] sets_log2,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] shifted;
  logic [IDX_W:0]    mask;

  always_comb begin
    shifted = addr >> line_log2;
    mask    = ((IDX_W+1)'(1) << sets_log2) - (IDX_W+1)'(1);
    idx     = shifted[IDX_W-1:0] & mask[IDX_W-1:0];
  end
endmodule

// File: rtl/sidx_polyhash.sv
module sidx_polyhash
  import sidx_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic [IDX_W-1:0]  idx
);
  localparam int TREES = 5;
  localparam int TAP_W = HASH_MSB + 1;
  localparam logic [TAP_W-1:0] TAPS [TREES] = '{
    TAP_W'((1<<7)|(1<<12)|(1<<15)|(1<<17)|(1<<18)|(1<<21)|(1<<22)|(1<<23)|(1<<24)|(1<<25)),
    TAP_W'((1<<8)|(1<<13)|(1<<16)|(1<<18)|(1<<19)|(1<<22)|(1<<23)|(1<<24)|(1<<25)|(1<<26)),
    TAP_W'((1<<9)|(1<<12)|(1<<14)|(1<<15)|(1<<18)|(1<<19)|(1<<20)|(1<<21)|(1<<22)|(1<<26)),
    TAP_W'((1<<10)|(1<<13)|(1<<15)|(1<<16)|(1<<19)|(1<<20)|(1<<21)|(1<<22)|(1<<23)),
    TAP_W'((1<<11)|(1<<14)|(1<<16)|(1<<17)|(1<<20)|(1<<21)|(1<<22)|(1<<23)|(1<<24))
  };

  logic [TAP_W-1:0] low_addr;
  assign low_addr = addr[TAP_W-1:0];

  for (genvar t = 0; t < TREES; t++) begin : g_tree
    assign idx[t] = ^(low_addr & TAPS[t]);
  end

  // top index bit passes address bit 12 straight through for 64-set caches
  assign idx[IDX_W-1] = wide & addr[12];
endmodule

// File: rtl/sidx_decode.sv
module sidx_decode
  import sidx_pkg::*;
(
  input  logic [POL_W-1:0]  policy,
  input  logic [SETS_W-1:0] sets_log2,
  output logic              use_hash,
  output logic              wide,
  output logic              bad
);
  logic pol_known;
  logic sets_ok;
  logic hash_size_ok;

  always_comb begin
    pol_known    = (policy <= POL_W'(POL_CUSTOM));
    sets_ok      = (sets_log2 <= SETS_W'(SETS_LOG2_MAX));
    wide         = (sets_log2 == SETS_W'(6));
    hash_size_ok = (sets_log2 == SETS_W'(5)) || wide;
    use_hash     = (policy == POL_W'(POL_POLYHASH));
    bad          = !pol_known || !sets_ok || (use_hash && !hash_size_ok);
  end
endmodule

// File: rtl/set_index_gen.sv
module set_index_gen
  import sidx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_policy_i,
  input  logic [2:0]        req_sets_log2_i,
  input  logic [LINE_W-1:0] req_line_log2_i,
  output logic [5:0]        idx_o,
  output logic              idx_valid_o,
  output logic              idx_err_o
);
  logic [IDX_W-1:0] lin_idx;
  logic [IDX_W-1:0] hash_idx;
  logic             use_hash;
  logic             wide;
  logic             bad;

  logic [IDX_W-1:0] idx_d,  idx_q;
  logic             vld_d,  vld_q;
  logic             err_d,  err_q;
  logic             idx_en;

  sidx_linear #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_lin (
    .addr      (req_addr_i),
    .line_log2 (req_line_log2_i),
    .sets_log2 (req_sets_log2_i),
    .idx       (lin_idx)
  );

  sidx_polyhash #(.ADDR_W(ADDR_W)) u_hash (
    .addr (req_addr_i),
    .wide (wide),
    .idx  (hash_idx)
  );

  sidx_decode u_dec (
    .policy    (req_policy_i),
    .sets_log2 (req_sets_log2_i),
    .use_hash  (use_hash),
    .wide      (wide),
    .bad       (bad)
  );

  always_comb begin
    idx_en = req_valid_i;
    vld_d  = req_valid_i;
    err_d  = req_valid_i && bad;
    if (bad)
      idx_d = '0;
    else if (use_hash)
      idx_d = hash_idx;
    else
      idx_d = lin_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      if (idx_en)
        idx_q <= idx_d;
    end
  end

  assign idx_o       = idx_q;
  assign idx_valid_o = vld_q;
  assign idx_err_o   = err_q;
endmodule

// File: rtl/sidx_chk.sv
module sidx_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [2:0]        req_policy_i,
  input logic [2:0]        req_sets_log2_i,
  input logic [5:0]        idx_o,
  input logic              idx_valid_o,
  input logic              idx_err_o
);
  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> idx_valid_o);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!idx_valid_o && !idx_err_o && $stable(idx_o)));
  // R10
  err_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err_o |-> (idx_valid_o && idx_o == 6'd0));
  // R7
  bad_policy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_policy_i > 3'd4) |=> idx_err_o);
  // R8
  bad_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_sets_log2_i == 3'd7) |=> idx_err_o);
  // R5
  hash_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_policy_i == 3'd2 && req_sets_log2_i != 3'd5 && req_sets_log2_i != 3'd6)
    |=> idx_err_o);
  // R4
  hash_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_policy_i == 3'd2 && req_sets_log2_i == 3'd6)
    |=> (!idx_err_o && idx_o[5] == $past(req_addr_i[12])));
  // R2
  linear_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_policy_i == 3'd0 && req_sets_log2_i <= 3'd6)
    |=> (!idx_err_o && (idx_o >> $past(req_sets_log2_i)) == 6'd0));
endmodule

bind set_index_gen sidx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid_i     (req_valid_i),
  .req_addr_i      (req_addr_i),
  .req_policy_i    (req_policy_i),
  .req_sets_log2_i (req_sets_log2_i),
  .idx_o           (idx_o),
  .idx_valid_o     (idx_valid_o),
  .idx_err_o       (idx_err_o)
);

// File: tb/set_index_gen_tb.sv
module set_index_gen_tb;
  localparam int ADDR_W = 64;
  localparam int LINE_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic [2:0]        req_policy_i;
  logic [2:0]        req_sets_log2_i;
  logic [LINE_W-1:0] req_line_log2_i;
  logic [5:0]        idx_o;
  logic              idx_valid_o;
  logic              idx_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  set_index_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dut (
    .clk, .rst_n, .req_valid_i, .req_addr_i, .req_policy_i,
    .req_sets_log2_i, .req_line_log2_i, .idx_o, .idx_valid_o, .idx_err_o
  );

  function automatic logic [5:0] ref_hash(logic [63:0] a, logic six);
    logic [5:0] r;
    r[0] = a[7]^a[12]^a[15]^a[17]^a[18]^a[21]^a[22]^a[23]^a[24]^a[25];
    r[1] = a[8]^a[13]^a[16]^a[18]^a[19]^a[22]^a[23]^a[24]^a[25]^a[26];
    r[2] = a[9]^a[12]^a[14]^a[15]^a[18]^a[19]^a[20]^a[21]^a[22]^a[26];
    r[3] = a[10]^a[13]^a[15]^a[16]^a[19]^a[20]^a[21]^a[22]^a[23];
    r[4] = a[11]^a[14]^a[16]^a[17]^a[20]^a[21]^a[22]^a[23]^a[24];
    r[5] = six ? a[12] : 1'b0;
    return r;
  endfunction

  // returns {err, idx}
  function automatic logic [6:0] ref_out(logic [63:0] a, logic [2:0] pol,
                                         logic [2:0] sl, logic [5:0] ls);
    logic [63:0] sh;
    int unsigned m;
    if (pol > 3'd4 || sl == 3'd7) return {1'b1, 6'd0};
    if (pol == 3'd2) begin
      if (sl == 3'd5) return {1'b0, ref_hash(a, 1'b0)};
      if (sl == 3'd6) return {1'b0, ref_hash(a, 1'b1)};
      return {1'b1, 6'd0};
    end
    sh = a >> ls;
    m  = (32'd1 << sl) - 1;
    return {1'b0, sh[5:0] & m[5:0]};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result appears after the next rising edge
  task automatic issue(string req, logic [63:0] a, logic [2:0] pol,
                       logic [2:0] sl, logic [5:0] ls);
    logic [6:0] e;
    e = ref_out(a, pol, sl, ls);
    req_valid_i = 1'b1; req_addr_i = a; req_policy_i = pol;
    req_sets_log2_i = sl; req_line_log2_i = ls;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req, {idx_err_o, idx_o}, e);
    check("R9 valid strobe", {6'd0, idx_valid_o}, 7'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] held;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
    req_policy_i = '0; req_sets_log2_i = '0; req_line_log2_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {idx_err_o, idx_valid_o, idx_o[4:0]}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {idx_err_o, idx_valid_o, idx_o[4:0]}, 7'd0);

    // R2 linear, directed
    issue("R2 linear 64 sets", 64'h0000_0000_0000_1FC0, 3'd0, 3'd6, 6'd6);
    issue("R2 linear 1 set", 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd0, 6'd0);
    issue("R2 linear max shift", 64'h8000_0000_0000_0000, 3'd0, 3'd6, 6'd63);
    // R3 one-hot addresses on each hashed bit, 32 sets
    for (int b = 7; b <= 26; b++)
      issue("R3 hash onehot", 64'd1 << b, 3'd2, 3'd5, 6'd7);
    issue("R3 hash ignores high bits", 64'hFFFF_FFFF_F800_0000, 3'd2, 3'd5, 6'd0);
    // R4 bit 12 feeds index bit 5
    issue("R4 hash 64 sets bit12", 64'd1 << 12, 3'd2, 3'd6, 6'd7);
    issue("R4 hash 64 sets", 64'h0000_0000_07FF_FF80, 3'd2, 3'd6, 6'd7);
    // R5 hash at unsupported size
    issue("R5 hash 16 sets", 64'h0000_0000_0123_4567, 3'd2, 3'd4, 6'd6);
    // R6 fallback policies
    issue("R6 xor policy", 64'h0000_0000_0000_ABCD, 3'd1, 3'd5, 6'd4);
    issue("R6 legacy policy", 64'h0000_0000_0000_ABCD, 3'd3, 3'd6, 6'd5);
    issue("R6 custom policy", 64'h0000_0000_0000_ABCD, 3'd4, 3'd3, 6'd2);
    // R7 undefined policy codes
    for (int p = 5; p <= 7; p++)
      issue("R7 bad policy", 64'h0000_0000_0000_FFFF, 3'(p), 3'd5, 6'd6);
    // R8 set log2 7
    issue("R8 bad sets", 64'h0000_0000_0000_FFFF, 3'd0, 3'd7, 6'd6);
    // R10 error forces zero index after a nonzero one
    issue("R10 nonzero before", 64'h0000_0000_0000_0FC0, 3'd0, 3'd6, 6'd6);
    issue("R10 error zeroes index", 64'h0000_0000_0000_0FC0, 3'd6, 3'd6, 6'd6);

    // R9 hold: new inputs without req_valid must not change outputs
    issue("R9 setup", 64'h0000_0000_0000_0AC0, 3'd0, 3'd6, 6'd6);
    held = {idx_err_o, idx_o};
    req_addr_i = 64'hFFFF_FFFF_FFFF_FFFF; req_policy_i = 3'd7;
    @(negedge clk);
    check("R9 idle valid low", {6'd0, idx_valid_o}, 7'd0);
    check("R9 idle index held", {idx_err_o, idx_o}, {1'b0, held[5:0]});

    // random mix, R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      issue("R2-random mix", a, 3'($urandom_range(0, 7)),
            3'($urandom_range(0, 7)), 6'($urandom_range(0, 63)));
    end

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule